// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block moves a small CPU from an accepted interrupt request into its handler. A hardware request is latched as pending and waits until the core signals that the current instruction has finished. On the next cycle the sequencer takes over a byte-wide memory bus. It performs an acknowledge read that returns the interrupt number and request level, then runs a fixed number of idle bus cycles. It then saves the pre-entry flag word and the 20-bit program counter to the stack as four byte writes, and fetches a three-byte handler address from the vector table.

When the last vector byte arrives, the block presents the new PC, the updated flag word and the lowered stack pointer, all for one cycle. A software interrupt instruction enters the same path with its own number. It does no acknowledge read and leaves the priority level alone. Its number also decides whether the stack-select flag is cleared.

Flag word bit positions: U is bit 7, I is bit 6, D is bit 5, and the priority level (IPL) occupies bits 14:12.

Top module: `irq_entry_seq`

## Requirements
- R1: The sequence starts only in the cycle after `insn_done_i` is sampled high while idle with a request available. Before that, `busy_o` stays low however long a request has been pending.
- R2: A hardware entry begins with a single read at address 0. The returned byte carries the interrupt number in bits 4:0 and the level in bits 7:5. This read clears the pending request.
- R3: After the acknowledge read, or right after start for a software entry, the bus idles for `IDLE_CYC` cycles with both `mem_rd_o` and `mem_wr_o` low. Read and write are never high together.
- R4: The stack saves are four byte writes, in this order: SP-2 gets PC[7:0], SP-1 gets PC[15:8], SP-4 gets flags[7:0], and SP-3 gets {flags[15:12], PC[19:16]}. Stack addresses wrap in 16 bits and are zero-extended onto the bus. The saved flags are the pre-entry values.
- R5: Three reads follow the saves, at VEC, VEC+1 and VEC+2, where VEC = `VEC_BASE` + 4*number. The new PC is {byte2[3:0], byte1, byte0}.
- R6: On a hardware entry the new flag word has I, D and U cleared and IPL set to the acknowledged level. All other bits are kept.
- R7: A software entry uses `sw_num_i` as its number and keeps IPL unchanged. It clears U only when the number is below 32; I and D are always cleared.
- R8: `busy_o` is high for the whole sequence. In the cycle after the last vector read, `done_o` pulses for one cycle, `sp_o` = SP-4, and `pc_o`/`flg_o` take their new values. These outputs hold at all other times.
- R9: Requests arriving while `busy_o` is high are dropped. After the sequence ends, a completed instruction does not start a new entry.
- R10: After reset `busy_o`, `done_o`, `mem_rd_o` and `mem_wr_o` are low, and `pc_o`, `flg_o` and `sp_o` are zero.
- R11: If a software entry and a pending hardware request meet on the same completed instruction, the software entry runs first. The hardware request stays pending and runs on the next completed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Hardware interrupt request pulse |
| insn_done_i | input | 1 | Current instruction has completed |
| sw_int_i | input | 1 | Completed instruction is a software interrupt |
| sw_num_i | input | 6 | Software interrupt number |
| pc_i | input | 20 | Program counter at entry |
| flg_i | input | 16 | Flag word at entry |
| sp_i | input | SP_W | Interrupt stack pointer at entry |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr_o | output | ADDR_W | Bus address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Entry sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 20 | Handler start address |
| flg_o | output | 16 | Updated flag word |
| sp_o | output | SP_W | Stack pointer after the saves |

## Verification
The bench aims at the scrambled stack order. A design that wrote the four bytes in ascending addresses, or swapped the PC and flag halves, would show wrong address/data pairs in the per-cycle trace. It drives level 7 with number 31, and a stack pointer of 2 so the stack addresses wrap. This catches a misplaced acknowledge field, a missing 4x vector scale and a carry leaking into the 20-bit bus.

Software numbers 10 and 40 separate a design that always or never clears U, or that overwrites IPL on software entries. A request injected mid-sequence and a software/hardware collision expose a pending latch that is not cleared by the acknowledge, or that loses the hardware request.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int PC_W     = 20;
  localparam int FLG_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int NUM_W    = 6;
  localparam int ACK_NUM_W = 5;
  localparam int IPL_W    = 3;
  localparam int FLG_U    = 7;
  localparam int FLG_I    = 6;
  localparam int FLG_D    = 5;
  localparam int IPL_LSB  = 12;
  localparam int SW_KEEP_U_MIN = 32;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACK, ST_GAP,
    ST_SV0, ST_SV1, ST_SV2, ST_SV3,
    ST_VC0, ST_VC1, ST_VC2
  } seq_st_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pend_q <= 1'b0;
    else if (ack_i)          pend_q <= 1'b0;
    else if (req_i && !busy_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

  AST_BUSY_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !pend_q) |=> !pend_q); // R9
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm import irq_seq_pkg::*; #(
  parameter int IDLE_CYC = 11
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    go_hw_i,
  input  logic    go_sw_i,
  output seq_st_e state_o
);
  localparam int CNT_W = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((IDLE_CYC > 0) ? IDLE_CYC - 1 : 0);
  localparam seq_st_e ST_POST = (IDLE_CYC == 0) ? ST_SV0 : ST_GAP;

  seq_st_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_hw_i) state_d = ST_ACK;
               else if (go_sw_i) state_d = ST_POST;
      ST_ACK:  state_d = ST_POST;
      ST_GAP:  if (cnt_q == '0) state_d = ST_SV0;
      ST_SV0:  state_d = ST_SV1;
      ST_SV1:  state_d = ST_SV2;
      ST_SV2:  state_d = ST_SV3;
      ST_SV3:  state_d = ST_VC0;
      ST_VC0:  state_d = ST_VC1;
      ST_VC1:  state_d = ST_VC2;
      ST_VC2:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_GAP && state_q != ST_GAP) cnt_q <= CNT_LOAD;
      else if (state_q == ST_GAP)                 cnt_q <= cnt_q - 1'b1;
    end
  end

  assign state_o = state_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !go_hw_i && !go_sw_i) |=> state_q == ST_IDLE); // R1
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp import irq_seq_pkg::*; #(
  parameter int          ADDR_W   = 20,
  parameter int          SP_W     = 16,
  parameter logic [19:0] VEC_BASE = 20'hFFD00
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  seq_st_e             state_i,
  input  logic                go_i,
  input  logic                go_sw_i,
  input  logic [NUM_W-1:0]    sw_num_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic [FLG_W-1:0]    flg_i,
  input  logic [SP_W-1:0]     sp_i,
  input  logic [BYTE_W-1:0]   rdata_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                rd_o,
  output logic                wr_o,
  output logic [BYTE_W-1:0]   wdata_o,
  output logic                done_o,
  output logic [PC_W-1:0]     pc_o,
  output logic [FLG_W-1:0]    flg_o,
  output logic [SP_W-1:0]     sp_o
);
  logic [PC_W-1:0]   pc_q;
  logic [FLG_W-1:0]  flg_q, flg_new;
  logic [SP_W-1:0]   sp_q;
  logic              sw_q;
  logic [NUM_W-1:0]  num_q;
  logic [IPL_W-1:0]  lvl_q;
  logic [BYTE_W-1:0] vb0_q, vb1_q;
  logic [ADDR_W-1:0] vec_a;

  assign vec_a = ADDR_W'(VEC_BASE) + ADDR_W'({num_q, 2'b00});

  function automatic logic [ADDR_W-1:0] stk(input logic [SP_W-1:0] sp, input int unsigned k);
    logic [SP_W-1:0] a;
    a = sp - SP_W'(k);
    return ADDR_W'(a);
  endfunction

  always_comb begin
    addr_o  = '0;
    rd_o    = 1'b0;
    wr_o    = 1'b0;
    wdata_o = '0;
    unique case (state_i)
      ST_ACK: rd_o = 1'b1;
      ST_SV0: begin wr_o = 1'b1; addr_o = stk(sp_q, 2); wdata_o = pc_q[7:0];  end
      ST_SV1: begin wr_o = 1'b1; addr_o = stk(sp_q, 1); wdata_o = pc_q[15:8]; end
      ST_SV2: begin wr_o = 1'b1; addr_o = stk(sp_q, 4); wdata_o = flg_q[7:0]; end
      ST_SV3: begin wr_o = 1'b1; addr_o = stk(sp_q, 3); wdata_o = {flg_q[15:12], pc_q[19:16]}; end
      ST_VC0: begin rd_o = 1'b1; addr_o = vec_a; end
      ST_VC1: begin rd_o = 1'b1; addr_o = vec_a + ADDR_W'(1); end
      ST_VC2: begin rd_o = 1'b1; addr_o = vec_a + ADDR_W'(2); end
      default: ;
    endcase
  end

  // flag update applied to the snapshot taken at entry
  always_comb begin
    flg_new = flg_q;
    flg_new[FLG_I] = 1'b0;
    flg_new[FLG_D] = 1'b0;
    if (!(sw_q && num_q >= NUM_W'(SW_KEEP_U_MIN))) flg_new[FLG_U] = 1'b0;
    if (!sw_q) flg_new[IPL_LSB +: IPL_W] = lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; flg_q <= '0; sp_q <= '0; sw_q <= 1'b0;
      num_q <= '0; lvl_q <= '0; vb0_q <= '0; vb1_q <= '0;
      done_o <= 1'b0; pc_o <= '0; flg_o <= '0; sp_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        pc_q  <= pc_i;
        flg_q <= flg_i;
        sp_q  <= sp_i;
        sw_q  <= go_sw_i;
        num_q <= go_sw_i ? sw_num_i : '0;
      end
      if (state_i == ST_ACK) begin
        num_q <= NUM_W'(rdata_i[ACK_NUM_W-1:0]);
        lvl_q <= rdata_i[BYTE_W-1 -: IPL_W];
      end
      if (state_i == ST_VC0) vb0_q <= rdata_i;
      if (state_i == ST_VC1) vb1_q <= rdata_i;
      if (state_i == ST_VC2) begin
        pc_o   <= {rdata_i[3:0], vb1_q, vb0_q};
        flg_o  <= flg_new;
        sp_o   <= sp_q - SP_W'(4);
        done_o <= 1'b1;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pc_o) && $stable(flg_o) && $stable(sp_o))); // R8
  AST_FIRST_SAVE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !$past(wr_o)) |-> addr_o[SP_W-1:0] == SP_W'(sp_q - SP_W'(2))); // R4
  AST_SAVE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (SP_W'(sp_q - addr_o[SP_W-1:0]) >= SP_W'(1) &&
              SP_W'(sp_q - addr_o[SP_W-1:0]) <= SP_W'(4))); // R4
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq import irq_seq_pkg::*; #(
  parameter int          ADDR_W   = 20,
  parameter int          SP_W     = 16,
  parameter int          IDLE_CYC = 11,
  parameter logic [19:0] VEC_BASE = 20'hFFD00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic              insn_done_i,
  input  logic              sw_int_i,
  input  logic [5:0]        sw_num_i,
  input  logic [19:0]       pc_i,
  input  logic [15:0]       flg_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [19:0]       pc_o,
  output logic [15:0]       flg_o,
  output logic [SP_W-1:0]   sp_o
);
  seq_st_e state;
  logic    pend, go_hw, go_sw, ack;

  assign busy_o = (state != ST_IDLE);
  assign ack    = (state == ST_ACK);
  assign go_sw  = !busy_o && insn_done_i && sw_int_i;
  assign go_hw  = !busy_o && insn_done_i && pend && !sw_int_i;

  irq_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_req_i),
    .busy_i (busy_o),
    .ack_i  (ack),
    .pend_o (pend)
  );

  irq_seq_fsm #(.IDLE_CYC(IDLE_CYC)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_hw_i (go_hw),
    .go_sw_i (go_sw),
    .state_o (state)
  );

  irq_seq_dp #(.ADDR_W(ADDR_W), .SP_W(SP_W), .VEC_BASE(VEC_BASE)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .go_i     (go_hw || go_sw),
    .go_sw_i  (go_sw),
    .sw_num_i (sw_num_i),
    .pc_i     (pc_i),
    .flg_i    (flg_i),
    .sp_i     (sp_i),
    .rdata_i  (mem_rdata_i),
    .addr_o   (mem_addr_o),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .wdata_o  (mem_wdata_o),
    .done_o   (done_o),
    .pc_o     (pc_o),
    .flg_o    (flg_o),
    .sp_o     (sp_o)
  );

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R3
  AST_START_AFTER_INSN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(insn_done_i)); // R1
  AST_ACK_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !$past(sw_int_i)) |-> (mem_rd_o && mem_addr_o == '0)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o) ##1 !done_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_rd_o && !mem_wr_o)); // R10
endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
  localparam int ADDR_W = 20;
  localparam int SP_W = 16;
  localparam int IDLE_CYC = 11;
  localparam logic [19:0] VEC_BASE = 20'hFFD00;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic irq_req_i = 1'b0, insn_done_i = 1'b0, sw_int_i = 1'b0;
  logic [5:0] sw_num_i = '0;
  logic [19:0] pc_i = '0;
  logic [15:0] flg_i = '0;
  logic [SP_W-1:0] sp_i = '0;
  logic [7:0] mem_rdata_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic mem_rd_o, mem_wr_o, busy_o, done_o;
  logic [7:0] mem_wdata_o;
  logic [19:0] pc_o;
  logic [15:0] flg_o;
  logic [SP_W-1:0] sp_o;
  logic [7:0] ack_byte = '0;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  logic tr_rd [0:63];
  logic tr_wr [0:63];
  logic [ADDR_W-1:0] tr_a [0:63];
  logic [7:0] tr_d [0:63];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] vbyte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  always_comb mem_rdata_i = (mem_addr_o == '0) ? ack_byte : vbyte(mem_addr_o);

  irq_entry_seq #(.ADDR_W(ADDR_W), .SP_W(SP_W), .IDLE_CYC(IDLE_CYC), .VEC_BASE(VEC_BASE)) u_irq_entry_seq (
    .clk_i(clk), .rst_ni(rst_ni), .irq_req_i(irq_req_i), .insn_done_i(insn_done_i),
    .sw_int_i(sw_int_i), .sw_num_i(sw_num_i), .pc_i(pc_i), .flg_i(flg_i), .sp_i(sp_i),
    .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .done_o(done_o),
    .pc_o(pc_o), .flg_o(flg_o), .sp_o(sp_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic t_reset();
    chk(busy_o == 0 && done_o == 0, "R10 busy/done", {busy_o, done_o}, 0);
    chk(mem_rd_o == 0 && mem_wr_o == 0, "R10 strobes", {mem_rd_o, mem_wr_o}, 0);
    chk(pc_o == 0 && flg_o == 0 && sp_o == 0, "R10 outputs", pc_o, 0);
  endtask

  task automatic do_entry(input bit sw, input logic [5:0] swn, input logic [19:0] pc,
                          input logic [15:0] flg, input logic [SP_W-1:0] sp,
                          input logic [7:0] ack, input bit give_req, input bit mid_req);
    int n, base, len;
    logic [5:0] num;
    logic [2:0] lvl;
    logic [ADDR_W-1:0] va;
    logic [15:0] ef;
    logic [19:0] ep;
    logic [SP_W-1:0] s;
    bit quiet;
    pc_i = pc; flg_i = flg; sp_i = sp; ack_byte = ack;
    if (give_req) begin
      irq_req_i = 1'b1; @(negedge clk); irq_req_i = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R1 waits for insn_done", busy_o, 0);
    insn_done_i = 1'b1; sw_int_i = sw; sw_num_i = swn;
    @(negedge clk);
    insn_done_i = 1'b0; sw_int_i = 1'b0;
    n = 0;
    while (busy_o && n < 64) begin
      tr_rd[n] = mem_rd_o; tr_wr[n] = mem_wr_o; tr_a[n] = mem_addr_o; tr_d[n] = mem_wdata_o;
      if (mid_req && n == 4) irq_req_i = 1'b1;
      if (n == 5) irq_req_i = 1'b0;
      @(negedge clk);
      n++;
    end
    irq_req_i = 1'b0;
    base = sw ? IDLE_CYC : IDLE_CYC + 1;
    len = base + 7;
    chk(n == len, "R8 busy length", n, len);
    if (n != len) return;
    num = sw ? swn : {1'b0, ack[4:0]};
    lvl = ack[7:5];
    if (!sw) chk(tr_rd[0] && !tr_wr[0] && tr_a[0] == 0, "R2 ack read at 0", tr_a[0], 0);
    else chk(!tr_rd[0], "R7 no ack read", tr_rd[0], 0);
    quiet = 1'b1;
    for (int i = base - IDLE_CYC; i < base; i++) if (tr_rd[i] || tr_wr[i]) quiet = 1'b0;
    chk(quiet, "R3 idle cycles", quiet, 1);
    s = sp - 2; chk(tr_wr[base] && tr_a[base] == ADDR_W'(s) && tr_d[base] == pc[7:0], "R4 save0", tr_a[base], ADDR_W'(s));
    s = sp - 1; chk(tr_wr[base+1] && tr_a[base+1] == ADDR_W'(s) && tr_d[base+1] == pc[15:8], "R4 save1", tr_a[base+1], ADDR_W'(s));
    s = sp - 4; chk(tr_wr[base+2] && tr_a[base+2] == ADDR_W'(s) && tr_d[base+2] == flg[7:0], "R4 save2", tr_a[base+2], ADDR_W'(s));
    s = sp - 3; chk(tr_wr[base+3] && tr_a[base+3] == ADDR_W'(s) && tr_d[base+3] == {flg[15:12], pc[19:16]}, "R4 save3", tr_d[base+3], {flg[15:12], pc[19:16]});
    va = VEC_BASE + ADDR_W'(num) * 4;
    for (int k = 0; k < 3; k++)
      chk(tr_rd[base+4+k] && tr_a[base+4+k] == va + ADDR_W'(k), "R5 vector address", tr_a[base+4+k], va + ADDR_W'(k));
    ep = {vbyte(va + 2) & 8'h0F, vbyte(va + 1), vbyte(va)};
    ep = {vbyte(va + 2)[3:0], vbyte(va + 1), vbyte(va)};
    ef = flg; ef[6] = 1'b0; ef[5] = 1'b0;
    if (!(sw && swn >= 6'd32)) ef[7] = 1'b0;
    if (!sw) ef[14:12] = lvl;
    chk(done_o == 1, "R8 done pulse", done_o, 1);
    chk(pc_o == ep, "R5 new pc", pc_o, ep);
    chk(flg_o == ef, sw ? "R7 sw flags" : "R6 hw flags", flg_o, ef);
    chk(sp_o == SP_W'(sp - 4), "R8 sp", sp_o, SP_W'(sp - 4));
    @(negedge clk);
    chk(done_o == 0 && pc_o == ep, "R8 done one cycle, hold", {done_o, pc_o}, {1'b0, ep});
  endtask

  task automatic t_hw_basic();
    do_entry(0, 6'd0, 20'h4_1234, 16'h03E0, 16'h8000, {3'd5, 5'd3}, 1, 0);
  endtask

  task automatic t_hw_edge();
    do_entry(0, 6'd0, 20'hF_FFFF, 16'hFFFF, 16'h0002, {3'd7, 5'd31}, 1, 0);
  endtask

  task automatic t_sw_low();
    do_entry(1, 6'd10, 20'h2_ABCD, 16'h50E0, 16'h1000, 8'h00, 0, 0);
  endtask

  task automatic t_sw_high();
    do_entry(1, 6'd40, 20'h0_0F0F, 16'h30E0, 16'h2000, 8'h00, 0, 0);
  endtask

  task automatic t_busy_ignore();
    do_entry(0, 6'd0, 20'h1_1111, 16'h0040, 16'h3000, {3'd2, 5'd9}, 1, 1);
    insn_done_i = 1'b1; @(negedge clk); insn_done_i = 1'b0;
    chk(busy_o == 0, "R9 no re-entry", busy_o, 0);
    @(negedge clk);
    chk(busy_o == 0 && !mem_rd_o, "R9 still idle", busy_o, 0);
  endtask

  task automatic t_prio();
    irq_req_i = 1'b1; @(negedge clk); irq_req_i = 1'b0;
    do_entry(1, 6'd12, 20'h3_0000, 16'h10E0, 16'h4000, {3'd4, 5'd6}, 0, 0);
    // R11: hardware request still pending, runs next
    do_entry(0, 6'd0, 20'h3_0100, 16'h00E0, 16'h4000, {3'd4, 5'd6}, 0, 0);
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=1 exp=0");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_hw_basic();
    t_hw_edge();
    t_sw_low();
    t_sw_high();
    t_busy_ignore();
    t_prio();
    finished = 1'b1;
    report();
    $finish;
  end
endmodule